// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers asynchronous serial characters from a single line. A clock enable pulse at sixteen times the bit rate times it. Each character has one low start bit, 5 to 8 data bits sent least significant first, an optional parity bit and one or two stop bits. The block turns it into a parallel byte. The byte and three per-character flags (parity error, framing error, break) go into a receive buffer. The buffer has sixteen entries in buffered mode and one entry in single-character mode.

A downstream register file reads the head of the buffer through a show-ahead port and pops it with a one-cycle read strobe. A data-ready output says that the buffer holds at least one character. A one-cycle overrun pulse marks a character that was lost because the buffer was full. A loopback select takes the serial stream from the local transmitter output instead of the external pin. A synchronous clear input empties the buffer.

Top module: `uart_rx_core`

## Requirements
- R1: `word_len` selects the data-bit count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits are taken least significant first, and the unused upper bits of `rd_data` read as zero.
- R2: When `parity_en` is 1, one parity bit follows the data bits. With `parity_even` = 1 the data and parity bits together must hold an even number of ones; with `parity_even` = 0 they must hold an odd number. A mismatch sets `rd_perr` on that character. When `parity_en` is 0, `rd_perr` is 0.
- R3: A character whose first stop bit samples low is stored with `rd_ferr` = 1. A character whose stop bit samples high is stored with `rd_ferr` = 0.
- R4: A low level that is high again at the start-bit midpoint (8 oversample ticks after the falling edge is seen) stores nothing. The receiver then accepts the next valid character.
- R5: If the start bit, all data bits, the parity bit (when enabled) and the first stop bit all sample low, exactly one entry is stored, with `rd_data` = 0 and `rd_brk` = 1. No further character is taken until the line has returned high.
- R6: With `fifo_mode` = 1 the buffer holds 16 characters and returns them in arrival order. `data_ready` is 1 exactly while the buffer is not empty.
- R7: A character that completes while the buffer is full is dropped, and `overrun` is high for one clock. The stored characters are left unchanged.
- R8: With `fifo_mode` = 0 the buffer holds one character, so a second unread character raises `overrun` and the first stays at the head.
- R9: `fifo_clear` empties the buffer, so `data_ready` is 0 in the cycle after it.
- R10: With `loopback_en` = 1 characters are taken from `loop_txd` and `rxd_pin` is ignored.
- R11: After reset `data_ready` and `overrun` are 0.
- R12: With `two_stop` = 1 the receiver waits out a second stop bit before it looks for the next start bit, and the character is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16x bit rate |
| rxd_pin | input | 1 | External serial input |
| loop_txd | input | 1 | Local transmitter output for loopback |
| loopback_en | input | 1 | 1 selects loop_txd as the serial source |
| word_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 even parity, 0 odd parity |
| two_stop | input | 1 | 1 waits for two stop bits |
| fifo_mode | input | 1 | 1 sixteen-entry buffer, 0 one entry |
| fifo_clear | input | 1 | Synchronous buffer flush |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head character data |
| rd_perr | output | 1 | Head parity error flag |
| rd_ferr | output | 1 | Head framing error flag |
| rd_brk | output | 1 | Head break flag |
| data_ready | output | 1 | Buffer not empty |
| overrun | output | 1 | One-cycle pulse, character dropped |

## Verification
If the bit counter or the word-length decode is wrong, every later character shows a shifted or truncated byte at `rd_data` about one character time after its stop bit. If the framer state is wrong after a false start or a break, the next character is lost, stored twice or stored as garbage within one character time. If the buffer pointers or occupancy count are wrong, the error shows as out-of-order data or a stuck `data_ready` on the next pop. An overrun off by one entry shows on the 16th or 17th character of a burst.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_STOP2,
    S_WAIT_HI
  } rx_state_t;

endpackage

// File: rtl/uart_rx_line_sel.sv
module uart_rx_line_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic loop_src,
  input  logic loop_en,
  output logic line_s
);

  logic                   src;
  logic [SYNC_STAGES-1:0] sync_q;

  assign src = loop_en ? loop_src : pin;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= src;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], src};
      end
    end
  endgenerate

  assign line_s = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic       two_stop,
  output logic       push,
  output rx_char_t   push_char
);

  localparam int CNTW = $clog2(OSR);
  localparam logic [CNTW-1:0] MID_LAST = CNTW'(OSR / 2 - 1);
  localparam logic [CNTW-1:0] BIT_LAST = CNTW'(OSR - 1);

  rx_state_t       state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [2:0]      idx_q, idx_d;
  logic [7:0]      sh_q, sh_d;
  logic            pbit_q, pbit_d;
  logic            push_d;
  rx_char_t        char_d;

  logic [2:0] last_idx;
  logic [7:0] data_al;
  logic       ones_odd;
  logic       is_break;

  assign last_idx = {1'b0, word_len} + 3'd4;
  assign data_al  = sh_q >> (2'd3 - word_len);
  assign ones_odd = ^data_al ^ pbit_q;
  assign is_break = (data_al == 8'd0) && !line && (!parity_en || !pbit_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    pbit_d  = pbit_q;
    push_d  = 1'b0;
    char_d  = '0;
    if (tick) begin
      cnt_d = cnt_q + 1'b1;
      unique case (state_q)
        S_IDLE: begin
          cnt_d = '0;
          if (!line) begin
            state_d = S_START;
            pbit_d  = 1'b0;
          end
        end
        S_START: begin
          if (cnt_q == MID_LAST) begin
            cnt_d   = '0;
            idx_d   = '0;
            state_d = line ? S_IDLE : S_DATA;
          end
        end
        S_DATA: begin
          if (cnt_q == BIT_LAST) begin
            sh_d = {line, sh_q[7:1]};
            if (idx_q == last_idx) state_d = parity_en ? S_PAR : S_STOP;
            else                   idx_d   = idx_q + 1'b1;
          end
        end
        S_PAR: begin
          if (cnt_q == BIT_LAST) begin
            pbit_d  = line;
            state_d = S_STOP;
          end
        end
        S_STOP: begin
          if (cnt_q == BIT_LAST) begin
            push_d = 1'b1;
            if (is_break) begin
              char_d  = '{brk: 1'b1, ferr: 1'b1, perr: 1'b0, data: 8'd0};
              state_d = S_WAIT_HI;
            end else begin
              char_d.data = data_al;
              char_d.ferr = !line;
              char_d.perr = parity_en && (parity_even ? ones_odd : !ones_odd);
              state_d     = two_stop ? S_STOP2 : S_IDLE;
            end
          end
        end
        S_STOP2: begin
          if (cnt_q == BIT_LAST) state_d = S_IDLE;
        end
        S_WAIT_HI: begin
          cnt_d = '0;
          if (line) state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      pbit_q    <= 1'b0;
      push      <= 1'b0;
      push_char <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      idx_q     <= idx_d;
      sh_q      <= sh_d;
      pbit_q    <= pbit_d;
      push      <= push_d;
      push_char <= char_d;
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_char_t wdata,
  input  logic     pop,
  input  logic     clear,
  input  logic     fifo_mode,
  output rx_char_t rdata,
  output logic     not_empty,
  output logic     overrun
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

  rx_char_t        mem [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [CW-1:0]   limit;
  logic            full, do_push, do_pop, ovr_d;

  assign limit   = fifo_mode ? FULL_N : CW'(1);
  assign full    = cnt_q >= limit;
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && (cnt_q != '0) && !clear;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovr_d = push && full && !clear;
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      overrun <= 1'b0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      cnt_q   <= cnt_d;
      overrun <= ovr_d;
    end
  end

  assign rdata     = mem[rd_q];
  assign not_empty = cnt_q != '0;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd_pin,
  input  logic       loop_txd,
  input  logic       loopback_en,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic       two_stop,
  input  logic       fifo_mode,
  input  logic       fifo_clear,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       data_ready,
  output logic       overrun
);

  logic     line_s;
  logic     push;
  rx_char_t push_char;
  rx_char_t head;

  uart_rx_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (rxd_pin),
    .loop_src (loop_txd),
    .loop_en  (loopback_en),
    .line_s   (line_s)
  );

  uart_rx_framer #(.OSR(OSR)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (baud_tick),
    .line        (line_s),
    .word_len    (word_len),
    .parity_en   (parity_en),
    .parity_even (parity_even),
    .two_stop    (two_stop),
    .push        (push),
    .push_char   (push_char)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .wdata     (push_char),
    .pop       (rd_en),
    .clear     (fifo_clear),
    .fifo_mode (fifo_mode),
    .rdata     (head),
    .not_empty (data_ready),
    .overrun   (overrun)
  );

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
  assign rd_brk  = head.brk;

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_clear,
  input logic       rd_en,
  input logic       data_ready,
  input logic       overrun,
  input logic       rd_brk,
  input logic [7:0] rd_data
);

  // R9: a flush leaves the buffer empty on the next cycle
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> !data_ready);

  // R7: a dropped character implies the buffer held data
  a_r7_overrun_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(data_ready));

  // R7: overrun is a single-cycle pulse
  a_r7_overrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);

  // R5: a break entry always carries zero data
  a_r5_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && rd_brk) |-> (rd_data == 8'd0));

  // R6: without a pop or flush the head stays put
  a_r6_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && !rd_en && !fifo_clear) |=> (data_ready && $stable(rd_data)));

endmodule

bind uart_rx_core uart_rx_core_chk u_chk (.*);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;
  localparam int NVEC     = 8;
  // {word_len, parity_en, parity_even, two_stop, bad_par, bad_stop, data}
  localparam logic [14:0] VEC [NVEC] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h2D},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h42},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC3}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic       rxd_pin, loop_txd, loopback_en;
  logic [1:0] word_len;
  logic       parity_en, parity_even, two_stop;
  logic       fifo_mode, fifo_clear, rd_en;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, data_ready, overrun;

  int checks = 0;
  int errors = 0;
  int ovr_cnt = 0;

  uart_rx_core u_dut (.*);

  always #4 clk = ~clk;

  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  always @(negedge clk) if (overrun === 1'b1) ovr_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input bit v, input bit lb);
    if (lb) loop_txd = v; else rxd_pin = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] wl, input bit pen, input bit peven,
                      input bit ts, input bit bad_par, input bit bad_stop,
                      input logic [7:0] d, input bit lb);
    logic [7:0] m;
    bit p;
    m = d & (8'hFF >> (2'd3 - wl));
    p = (^m) ^ !peven ^ bad_par;
    word_len = wl; parity_en = pen; parity_even = peven; two_stop = ts;
    drive_bit(1'b0, lb);
    for (int i = 0; i < 5 + int'(wl); i++) drive_bit(m[i], lb);
    if (pen) drive_bit(p, lb);
    drive_bit(!bad_stop, lb);
    if (ts) drive_bit(1'b1, lb);
    drive_bit(1'b1, lb);
    drive_bit(1'b1, lb);
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send8(input logic [7:0] d);
    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, d, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int base;
    rst_n = 1'b0; rxd_pin = 1'b1; loop_txd = 1'b1; loopback_en = 1'b0;
    word_len = 2'd3; parity_en = 1'b0; parity_even = 1'b0; two_stop = 1'b0;
    fifo_mode = 1'b1; fifo_clear = 1'b0; rd_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(data_ready === 1'b0, "R11 ready", int'(data_ready), 0);
    chk(overrun === 1'b0, "R11 overrun", int'(overrun), 0);

    // vector table: R1 lengths, R2 parity, R3 framing, R12 two stop bits
    for (int v = 0; v < NVEC; v++) begin
      logic [14:0] e;
      logic [7:0]  xd;
      e  = VEC[v];
      xd = e[7:0] & (8'hFF >> (2'd3 - e[14:13]));
      send(e[14:13], e[12], e[11], e[10], e[9], e[8], e[7:0], 1'b0);
      chk(data_ready === 1'b1, "R1 ready", int'(data_ready), 1);
      chk(rd_data === xd, e[10] ? "R12 data" : "R1 data", int'(rd_data), int'(xd));
      chk(rd_perr === (e[12] & e[9]), "R2 parity flag", int'(rd_perr), int'(e[12] & e[9]));
      chk(rd_ferr === e[8], "R3 framing flag", int'(rd_ferr), int'(e[8]));
      pop();
    end

    // R4: false start glitch
    word_len = 2'd3; parity_en = 1'b0; two_stop = 1'b0;
    rxd_pin = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxd_pin = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    chk(data_ready === 1'b0, "R4 no char", int'(data_ready), 0);
    send8(8'h37);
    chk(rd_data === 8'h37, "R4 next char", int'(rd_data), 8'h37);
    pop();

    // R5: break
    rxd_pin = 1'b0;
    repeat (14 * BIT_CLK) @(negedge clk);
    rxd_pin = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    chk(data_ready === 1'b1 && rd_brk === 1'b1, "R5 break flag", int'(rd_brk), 1);
    chk(rd_data === 8'h00, "R5 break data", int'(rd_data), 0);
    pop();
    chk(data_ready === 1'b0, "R5 single entry", int'(data_ready), 0);

    // R10: loopback, pin held low
    loopback_en = 1'b1;
    rxd_pin = 1'b0;
    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h96, 1'b1);
    chk(rd_data === 8'h96 && rd_brk === 1'b0, "R10 loop data", int'(rd_data), 8'h96);
    pop();
    chk(data_ready === 1'b0, "R10 pin ignored", int'(data_ready), 0);
    rxd_pin = 1'b1;
    repeat (4) @(negedge clk);
    loopback_en = 1'b0;
    repeat (2 * BIT_CLK) @(negedge clk);

    // R6, R7: fill the sixteen-entry buffer, then overflow
    for (int i = 0; i < 16; i++) send8(8'(i * 7 + 1));
    chk(data_ready === 1'b1, "R6 ready", int'(data_ready), 1);
    base = ovr_cnt;
    send8(8'hEE);
    chk(ovr_cnt == base + 1, "R7 overrun pulse", ovr_cnt - base, 1);
    for (int i = 0; i < 16; i++) begin
      chk(rd_data === 8'(i * 7 + 1), "R6 order", int'(rd_data), i * 7 + 1);
      pop();
    end
    chk(data_ready === 1'b0, "R6 empty", int'(data_ready), 0);

    // R8: single-character mode
    fifo_mode = 1'b0;
    base = ovr_cnt;
    send8(8'h11);
    chk(ovr_cnt == base, "R8 no overrun first", ovr_cnt - base, 0);
    send8(8'h22);
    chk(ovr_cnt == base + 1, "R8 overrun second", ovr_cnt - base, 1);
    chk(rd_data === 8'h11, "R8 head kept", int'(rd_data), 8'h11);
    pop();
    chk(data_ready === 1'b0, "R8 depth one", int'(data_ready), 0);

    // R9: flush
    fifo_mode = 1'b1;
    send8(8'h44);
    send8(8'h55);
    fifo_clear = 1'b1;
    @(negedge clk);
    fifo_clear = 1'b0;
    chk(data_ready === 1'b0, "R9 flushed", int'(data_ready), 0);
    send8(8'h66);
    chk(rd_data === 8'h66, "R9 after flush", int'(rd_data), 8'h66);

    finish_run();
  end

endmodule